// File: doc/BRIEF.md
# UART Transmitter with Ready and Empty Status

This block turns characters written by a CPU into an asynchronous serial stream. It has two storage stages. A one-character holding register takes CPU writes. A shift register serialises one frame at a time. When the shifter is free and the holding register has a character, the character moves into the shifter. It is then sent as one low start bit, five to eight data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Every bit lasts sixteen pulses of an external 16x clock enable. The line stays high whenever no frame is being sent.

The CPU watches two flags. `tx_ready` means the holding register can take a character. `tx_empty` means the holding register and the shifter are both empty, so the line has gone quiet. A transmitter enable gates the whole path. Dropping the enable aborts the frame in flight, drops any pending character, and clears both flags. Raising the enable sets both flags again.

The serialiser is a state machine with five states:
- `ST_IDLE`: the line is high. IDLE→START when a character is pending.
- `ST_START`: the line is low. START→DATA after sixteen ticks.
- `ST_DATA`: one data bit per sixteen ticks. DATA→PARITY, or DATA→STOP when parity is off, after the last programmed data bit.
- `ST_PARITY`: the parity bit is sent. PARITY→STOP after sixteen ticks.
- `ST_STOP`: the line is high. At the end of the last stop bit, STOP→START if a character is pending, otherwise STOP→IDLE.

From every state, a low enable forces the machine to IDLE.

Top module: `uart_tx_status`

## Requirements
- R1: While `rst_n` is low, `txd` is 1, `tx_ready` is 0 and `tx_empty` is 0. On the first clock edge at which `tx_en` is 1 after having been 0 (or after reset), both `tx_ready` and `tx_empty` become 1.
- R2: A frame is sent as follows: a start bit of 0, then the data bits with the LSB first, then optional parity, then stop bits of 1. Each bit lasts exactly 16 cycles in which `tick16` is 1, and the line does not change while `tick16` is 0. `cfg_len` sets the data length: 0=5, 1=6, 2=7, 3=8 bits.
- R3: `cfg_par` sets the parity. 0 and 3 mean no parity bit. 1 means even parity: the parity bit is the XOR of the sent data bits. 2 means odd parity: the parity bit is the inverse of that XOR.
- R4: `cfg_stop2`=0 sends one stop bit and `cfg_stop2`=1 sends two. The configuration is sampled when a character enters the shifter.
- R5: `tx_ready` rises on the same edge at which the pending character enters the shifter. For an idle shifter, that is the edge after the write, and `txd` falls to 0 on that edge.
- R6: A write accepted while `tx_ready` is 1 clears `tx_ready` on that edge.
- R7: `tx_empty` becomes 1 on the edge that ends the last stop bit, provided no character is pending. An accepted write clears `tx_empty` on that edge. While `tx_empty` is 1, `tx_ready` is 1 and `txd` is 1.
- R8: While `tx_en` is 0, the next edge returns `txd` to 1, clears both flags, and drops the frame in flight and any pending character. No frame follows re-enabling unless a new character is written.
- R9: A write while `tx_ready` is 0 is ignored. This includes writes while the hold register is full and writes while disabled. The ignored character is never sent.
- R10: A character pending at the end of a stop bit starts its start bit on that very edge, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | 16x bit-rate clock enable |
| tx_en | input | 1 | Transmitter enable |
| wr_valid | input | 1 | CPU write strobe for the holding register |
| wr_data | input | DATA_W | Character to send (LSB first) |
| cfg_len | input | LEN_W | Data length code, length = 5 + code |
| cfg_par | input | 2 | Parity mode: 0/3 none, 1 even, 2 odd |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
The hardest case to reach is the edge that ends a stop bit while a character is already waiting. At that single edge, a frame has to end and the next one has to begin with no gap, and `tx_empty` must stay low. The stimulus writes a second character as soon as `tx_ready` returns after the first frame is loaded. It then writes a third character while the holding register is full. The bench then checks the following:
- the line at the exact edge that ends the first frame and starts the second;
- the contents of the second frame;
- that `tx_empty` rises after the second frame, which shows the third write left no trace.

Frames are also checked for every combination of length, parity code and stop count. One frame also has a long stretch with `tick16` held low inside its start bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        PAR_OFF   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_ODD   = 2'b10,
        PAR_OFF_B = 2'b11
    } par_mode_t;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              en_rise,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              ready,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    logic              ready_q;
    logic              full_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            full_q  <= 1'b0;
            data_q  <= '0;
        end else if (!tx_en) begin
            ready_q <= 1'b0;
            full_q  <= 1'b0;
        end else if (take) begin
            full_q  <= 1'b0;
            ready_q <= 1'b1;
        end else if (wr_valid && ready_q) begin
            full_q  <= 1'b1;
            ready_q <= 1'b0;
            data_q  <= wr_data;
        end else if (en_rise) begin
            ready_q <= 1'b1;
        end
    end

    assign ready = ready_q;
    assign full  = full_q;
    assign data  = data_q;

    AST_HOLD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_q && full_q)); // R6

    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !ready_q && !take) |=> $stable(data_q)); // R9

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MIN_LEN    = 5,
    parameter int OVERSAMPLE = 16,
    localparam int LEN_W     = $clog2(DATA_W - MIN_LEN + 1),
    localparam int CNT_W     = $clog2(DATA_W + 1),
    localparam int TW        = $clog2(OVERSAMPLE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tick,
    input  logic              pend,
    input  logic [DATA_W-1:0] pend_data,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_stop2,
    output logic              take,
    output logic              done,
    output logic              busy,
    output logic              txd
);

    tx_state_t          state_q, state_d;
    logic [TW-1:0]      tcnt_q;
    logic [CNT_W-1:0]   bcnt_q;
    logic [CNT_W-1:0]   nbits_q;
    logic [DATA_W-1:0]  shreg_q;
    logic               par_bit_q;
    logic               par_on_q;
    logic               stop2_q;

    logic               bit_end;
    logic               last_data;
    logic               last_stop;
    logic [CNT_W-1:0]   load_len;
    logic [DATA_W-1:0]  load_mask;
    logic               load_xor;
    par_mode_t          pmode;

    assign pmode     = par_mode_t'(cfg_par);
    assign load_len  = CNT_W'(MIN_LEN) + CNT_W'(cfg_len);
    assign bit_end   = tick && (tcnt_q == TW'(OVERSAMPLE - 1));
    assign last_data = (bcnt_q == nbits_q - CNT_W'(1));
    assign last_stop = (state_q == ST_STOP) && bit_end &&
                       (bcnt_q == (stop2_q ? CNT_W'(1) : CNT_W'(0)));
    assign take      = tx_en && pend && ((state_q == ST_IDLE) || last_stop);
    assign done      = tx_en && last_stop;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            load_mask[i] = (i < int'(load_len));
        end
        load_xor = ^(pend_data & load_mask);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take) state_d = ST_START;
            ST_START:  if (bit_end) state_d = ST_DATA;
            ST_DATA:   if (bit_end && last_data) state_d = par_on_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP:   if (last_stop) state_d = take ? ST_START : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (!tx_en) state_d = ST_IDLE;
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tcnt_q    <= '0;
            bcnt_q    <= '0;
            nbits_q   <= CNT_W'(DATA_W);
            shreg_q   <= '0;
            par_bit_q <= 1'b0;
            par_on_q  <= 1'b0;
            stop2_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!tx_en) begin
                tcnt_q <= '0;
                bcnt_q <= '0;
            end else if (take) begin
                tcnt_q    <= '0;
                bcnt_q    <= '0;
                shreg_q   <= pend_data;
                nbits_q   <= load_len;
                par_on_q  <= (pmode == PAR_EVEN) || (pmode == PAR_ODD);
                par_bit_q <= (pmode == PAR_ODD) ? ~load_xor : load_xor;
                stop2_q   <= cfg_stop2;
            end else if (bit_end) begin
                tcnt_q <= '0;
                if (state_q == ST_DATA) begin
                    shreg_q <= shreg_q >> 1;
                    bcnt_q  <= last_data ? '0 : bcnt_q + CNT_W'(1);
                end else if (state_q == ST_STOP) begin
                    bcnt_q <= bcnt_q + CNT_W'(1);
                end
            end else if (tick && (state_q != ST_IDLE)) begin
                tcnt_q <= tcnt_q + TW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg_q[0];
            ST_PARITY: txd = par_bit_q;
            default:   txd = 1'b1;
        endcase
    end

    AST_LOAD_BEFORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(take)); // R5

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !take) |=> !busy); // R7

endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MIN_LEN    = 5,
    parameter int OVERSAMPLE = 16,
    localparam int LEN_W     = $clog2(DATA_W - MIN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_stop2,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty
);

    logic              en_q;
    logic              en_rise;
    logic              empty_q;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              done;
    logic              busy;
    logic              wr_ok;

    assign en_rise = tx_en && !en_q;
    assign wr_ok   = wr_valid && tx_ready;

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .en_rise  (en_rise),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .ready    (tx_ready),
        .full     (hold_full),
        .data     (hold_data)
    );

    uart_tx_fsm #(
        .DATA_W     (DATA_W),
        .MIN_LEN    (MIN_LEN),
        .OVERSAMPLE (OVERSAMPLE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .tick      (tick16),
        .pend      (hold_full),
        .pend_data (hold_data),
        .cfg_len   (cfg_len),
        .cfg_par   (cfg_par),
        .cfg_stop2 (cfg_stop2),
        .take      (take),
        .done      (done),
        .busy      (busy),
        .txd       (txd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            empty_q <= 1'b0;
        end else begin
            en_q <= tx_en;
            if (!tx_en)
                empty_q <= 1'b0;
            else if (wr_ok)
                empty_q <= 1'b0;
            else if (done && !take)
                empty_q <= 1'b1;
            else if (en_rise)
                empty_q <= 1'b1;
        end
    end

    assign tx_empty = empty_q;

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!tx_ready && !tx_empty && txd)); // R8

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && tx_ready) |=> (!tx_ready && !tx_empty)); // R6

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (txd && !busy)); // R7

    AST_EMPTY_HAS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready); // R7

endmodule

// File: tb/test_uart_tx_status.sv
module test_uart_tx_status;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick16;
    logic       tx_en;
    logic       wr_valid;
    logic [7:0] wr_data;
    logic [1:0] cfg_len;
    logic [1:0] cfg_par;
    logic       cfg_stop2;
    logic       txd;
    logic       tx_ready;
    logic       tx_empty;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    uart_tx_status i_uart_tx_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick16    (tick16),
        .tx_en     (tx_en),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .cfg_len   (cfg_len),
        .cfg_par   (cfg_par),
        .cfg_stop2 (cfg_stop2),
        .txd       (txd),
        .tx_ready  (tx_ready),
        .tx_empty  (tx_empty)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // write on the next edge; returns at the negedge right after it
    task automatic send(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // called 'pre' negedges after the negedge following the load edge;
    // returns at the negedge just before the edge that ends the frame
    task automatic check_frame(input logic [7:0] d, input int len, input int par,
                               input bit s2, input int stall, input int pre,
                               input string req);
        logic bits [0:15];
        int   n;
        logic p;
        n = 0;
        p = 1'b0;
        bits[n++] = 1'b0;
        for (int i = 0; i < len; i++) begin
            bits[n++] = d[i];
            p = p ^ d[i];
        end
        if (par == 1) bits[n++] = p;
        if (par == 2) bits[n++] = ~p;
        bits[n++] = 1'b1;
        if (s2) bits[n++] = 1'b1;
        if (stall > 0) begin
            tick16 = 1'b0;
            repeat (stall) @(negedge clk);
            chk(txd == 1'b0, "R2", "line moved without tick16", int'(txd), 0);
            tick16 = 1'b1;
        end
        repeat (8 - pre) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (i > 0) repeat (16) @(negedge clk);
            chk(txd == bits[i], req, $sformatf("bit %0d len %0d par %0d stop2 %0d", i, len, par, s2),
                int'(txd), int'(bits[i]));
        end
        repeat (7) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit         quiet;
        rst_n = 1'b0; tick16 = 1'b1; tx_en = 1'b1; wr_valid = 1'b0;
        wr_data = '0; cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop2 = 1'b0;
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1", "reset txd", int'(txd), 1);
        chk(tx_ready == 1'b0, "R1", "reset ready", int'(tx_ready), 0);
        chk(tx_empty == 1'b0, "R1", "reset empty", int'(tx_empty), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_ready == 1'b1, "R1", "ready after enable", int'(tx_ready), 1);
        chk(tx_empty == 1'b1, "R1", "empty after enable", int'(tx_empty), 1);

        // sweep every length, parity code and stop count (R2 R3 R4)
        for (int ln = 0; ln < 4; ln++) begin
            for (int pm = 0; pm < 4; pm++) begin
                for (int s2 = 0; s2 < 2; s2++) begin
                    for (int k = 0; k < 2; k++) begin
                        d = 8'((ln * 37 + pm * 11 + s2 * 5 + k * 165) ^ 8'h3C);
                        @(negedge clk);
                        cfg_len = 2'(ln); cfg_par = 2'(pm); cfg_stop2 = 1'(s2);
                        send(d);
                        chk(tx_ready == 1'b0, "R6", "ready after write", int'(tx_ready), 0);
                        chk(tx_empty == 1'b0, "R7", "empty after write", int'(tx_empty), 0);
                        @(negedge clk);
                        chk(tx_ready == 1'b1, "R5", "ready at load", int'(tx_ready), 1);
                        chk(txd == 1'b0, "R5", "start bit at load", int'(txd), 0);
                        check_frame(d, ln + 5, (pm == 3) ? 0 : pm, 1'(s2),
                                    (ln == 2 && pm == 1 && k == 1) ? 37 : 0, 0,
                                    (pm == 1 || pm == 2) ? "R3" : (s2 == 1 ? "R4" : "R2"));
                        chk(tx_empty == 1'b0, "R7", "empty before last stop ends", int'(tx_empty), 0);
                        @(negedge clk);
                        chk(tx_empty == 1'b1, "R7", "empty after last stop", int'(tx_empty), 1);
                        chk(txd == 1'b1, "R7", "line idle when empty", int'(txd), 1);
                    end
                end
            end
        end

        // back-to-back frames with an ignored write (R10 R9)
        @(negedge clk);
        cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop2 = 1'b0;
        send(8'hA6);
        @(negedge clk);
        send(8'h5B);
        chk(tx_ready == 1'b0, "R9", "hold full", int'(tx_ready), 0);
        send(8'hFF);
        check_frame(8'hA6, 8, 0, 1'b0, 0, 4, "R10");
        chk(txd == 1'b1, "R10", "stop bit before next frame", int'(txd), 1);
        @(negedge clk);
        chk(txd == 1'b0, "R10", "no gap before next start", int'(txd), 0);
        chk(tx_empty == 1'b0, "R10", "empty with pending char", int'(tx_empty), 0);
        chk(tx_ready == 1'b1, "R10", "ready at second load", int'(tx_ready), 1);
        check_frame(8'h5B, 8, 0, 1'b0, 0, 0, "R9");
        @(negedge clk);
        chk(tx_empty == 1'b1, "R9", "empty after second frame", int'(tx_empty), 1);
        quiet = 1'b1;
        repeat (200) begin
            @(negedge clk);
            if (txd !== 1'b1) quiet = 1'b0;
        end
        chk(quiet, "R9", "ignored write never sent", int'(quiet), 1);

        // disable in mid-frame with a pending character (R8)
        send(8'h81);
        @(negedge clk);
        send(8'h42);
        repeat (30) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R8", "line high when disabled", int'(txd), 1);
        chk(tx_ready == 1'b0, "R8", "ready cleared", int'(tx_ready), 0);
        chk(tx_empty == 1'b0, "R8", "empty cleared", int'(tx_empty), 0);
        send(8'h00);
        chk(tx_ready == 1'b0, "R9", "write while disabled", int'(tx_ready), 0);
        tx_en = 1'b1;
        @(negedge clk);
        chk(tx_ready == 1'b1, "R8", "ready on re-enable", int'(tx_ready), 1);
        chk(tx_empty == 1'b1, "R8", "empty on re-enable", int'(tx_empty), 1);
        quiet = 1'b1;
        repeat (300) begin
            @(negedge clk);
            if (txd !== 1'b1) quiet = 1'b0;
        end
        chk(quiet, "R8", "no frame after re-enable", int'(quiet), 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule